// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block watches over a four-channel half-bridge power output stage. It does no analog work. Each clock it takes a digitised die temperature code, one overcurrent flag per half-bridge and a digitised supply voltage code. From these it drives three outputs: an active-low early thermal warning, an active-low fault flag, and a disable signal that turns every power switch off so the outputs float.

Overcurrent and over-temperature events are held in a fault latch. The latch is cleared from outside by taking the tristate control input high, then low, then high again. The thermal trip has a wide hysteresis band, so the die must cool well below the trip point before the fault can be cleared. Undervoltage only disables the outputs while it lasts and is never latched. If the fault flag is wired back to the tristate input through a delay network, the stage retries on its own until the cause goes away.

Both flags behave as open-drain outputs. A 0 means asserted. A 1 means released, and an external pull-up then sets the level.

Top module: `pstage_fault_sup`

## Requirements
- R1: `warn_n` is 0 exactly when `temp_code` is greater than WARN_CODE (130, at 1 code per °C), whatever the fault state. It is 1 at 130 and below.
- R2: `temp_code` ≥ TRIP_CODE (150) drives `fault_n` to 0 and `out_off` to 1 in the same cycle. The thermal condition persists until `temp_code` ≤ TRIP_CODE − HYST_CODE (125), and the fault cannot be cleared while it persists.
- R3: Any set bit of `ovc_flag[3:0]` drives `fault_n` to 0 and `out_off` to 1 in the same cycle.
- R4: `vsup_code` below UV_CODE (35, in units of 0.1 V) drives `out_off` to 1 and leaves `fault_n` at 1. At 35 or above, the outputs are enabled again with no clearing step.
- R5: After an overcurrent or thermal condition goes away, `fault_n` stays 0 and `out_off` stays 1 until the clearing sequence completes.
- R6: The clearing sequence is a high-to-low transition of `tri_n` followed by a low-to-high transition. `tri_n` passes through a two-flop synchroniser, so the latch releases on the third rising clock edge after `tri_n` returns high, and not before.
- R7: `tri_n` at 0 or `pwr_en` at 0 forces `out_off` to 1 in the same cycle, whatever the fault state, and does not change `fault_n`.
- R8: If an overcurrent or thermal condition is still present when the clearing sequence completes, `fault_n` stays 0.
- R9: After reset, with no fault inputs active, `fault_n` and `warn_n` are 1 and `out_off` is 0 while `tri_n` and `pwr_en` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | 8 | Die temperature, 1 code per °C |
| ovc_flag | input | 4 | Overcurrent flag, one bit per half-bridge |
| vsup_code | input | 8 | Supply voltage, 0.1 V per code |
| pwr_en | input | 1 | 0 = power-down, all switches off |
| tri_n | input | 1 | 0 = all switches off; high-low-high clears the latched fault |
| warn_n | output | 1 | Open-drain thermal warning, 0 = warm |
| fault_n | output | 1 | Open-drain fault flag, 0 = fault |
| out_off | output | 1 | 1 = force every power switch off |

## Verification
The bench checks the thresholds exactly at their edges: 130 against 131 for the warning, 34 against 35 for the supply, and 126 against 125 for thermal release. An off-by-one comparison would move one of these by a code. It counts clock edges after `tri_n` returns high. A design that skipped the synchroniser would clear early, and one that needed a longer sequence would clear late. It also completes a clearing sequence while an overcurrent or hot condition is still present. A design that cleared blindly would show `fault_n` at 1 there, and one that latched undervoltage would stay disabled after the supply recovers.

// File: rtl/pstage_fault_sup.sv
module pstage_fault_sup #(
  parameter int TEMP_W    = 8,
  parameter int VS_W      = 8,
  parameter int NBR       = 4,
  parameter int WARN_CODE = 130,
  parameter int TRIP_CODE = 150,
  parameter int HYST_CODE = 25,
  parameter int UV_CODE   = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [NBR-1:0]    ovc_flag,
  input  logic [VS_W-1:0]   vsup_code,
  input  logic              pwr_en,
  input  logic              tri_n,
  output logic              warn_n,
  output logic              fault_n,
  output logic              out_off
);
  localparam logic [TEMP_W-1:0] WARN_T = TEMP_W'(WARN_CODE);
  localparam logic [TEMP_W-1:0] TRIP_T = TEMP_W'(TRIP_CODE);
  localparam logic [TEMP_W-1:0] REL_T  = TEMP_W'(TRIP_CODE - HYST_CODE);
  localparam logic [VS_W-1:0]   UV_T   = VS_W'(UV_CODE);

  logic [2:0] tri_sync;
  logic       armed, therm_hot, flt_latch;
  logic       rise, fall, clr, hot_now, cond, uv;

  assign rise    = tri_sync[1] & ~tri_sync[2];
  assign fall    = ~tri_sync[1] & tri_sync[2];
  assign clr     = rise & armed;
  assign hot_now = (temp_code >= TRIP_T) | therm_hot;
  assign cond    = (|ovc_flag) | hot_now;
  assign uv      = vsup_code < UV_T;

  assign warn_n  = ~(temp_code > WARN_T);
  assign fault_n = ~(cond | flt_latch);
  assign out_off = cond | flt_latch | uv | ~pwr_en | ~tri_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tri_sync  <= 3'b111;
      armed     <= 1'b0;
      therm_hot <= 1'b0;
      flt_latch <= 1'b0;
    end else begin
      tri_sync <= {tri_sync[1:0], tri_n};
      if (fall)      armed <= 1'b1;
      else if (rise) armed <= 1'b0;
      if (temp_code >= TRIP_T)     therm_hot <= 1'b1;
      else if (temp_code <= REL_T) therm_hot <= 1'b0;
      if (cond)     flt_latch <= 1'b1;
      else if (clr) flt_latch <= 1'b0;
    end
  end

  AST_THERM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (therm_hot && temp_code > REL_T) |=> !fault_n); // R2
  AST_OCP_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovc_flag) |-> (!fault_n && out_off)); // R3
  AST_UV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    uv |-> out_off); // R4
  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !clr) |=> !fault_n); // R5
  AST_TRI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!tri_n || !pwr_en) |-> out_off); // R7
endmodule

// File: tb/pstage_fault_sup_tb.sv
`timescale 1ns/1ps
module pstage_fault_sup_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] temp_code = 8'd25;
  logic [3:0] ovc_flag = 4'h0;
  logic [7:0] vsup_code = 8'd120;
  logic       pwr_en = 1'b1;
  logic       tri_n = 1'b1;
  logic       warn_n, fault_n, out_off;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pstage_fault_sup dut_i (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .ovc_flag(ovc_flag),
    .vsup_code(vsup_code), .pwr_en(pwr_en), .tri_n(tri_n),
    .warn_n(warn_n), .fault_n(fault_n), .out_off(out_off)
  );

  // {req, temp, ovc, vsup, pwr_en, tri_n, exp warn_n, exp fault_n, exp out_off}
  localparam int NV = 9;
  localparam logic [28:0] VEC [NV] = '{
    {4'd9, 8'd25,  4'h0, 8'd120, 5'b11110}, // R9 idle
    {4'd1, 8'd130, 4'h0, 8'd120, 5'b11110}, // R1 at threshold
    {4'd1, 8'd131, 4'h0, 8'd120, 5'b11010}, // R1 above
    {4'd1, 8'd149, 4'h0, 8'd120, 5'b11010}, // R1 just below trip
    {4'd4, 8'd60,  4'h0, 8'd34,  5'b11111}, // R4 undervoltage
    {4'd4, 8'd60,  4'h0, 8'd35,  5'b11110}, // R4 recovered
    {4'd7, 8'd60,  4'h0, 8'd120, 5'b01111}, // R7 power-down
    {4'd7, 8'd60,  4'h0, 8'd120, 5'b10111}, // R7 tristate low
    {4'd7, 8'd140, 4'h0, 8'd120, 5'b10011}  // R7 tristate, R1 warm
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic clear_seq();
    @(negedge clk) tri_n = 1'b0;
    repeat (4) @(negedge clk);
    tri_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "fault_n", fault_n, 1'b1);
    check("R9", "warn_n", warn_n, 1'b1);
    check("R9", "out_off", out_off, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      temp_code = VEC[i][24:17];
      ovc_flag  = VEC[i][16:13];
      vsup_code = VEC[i][12:5];
      pwr_en    = VEC[i][4];
      tri_n     = VEC[i][3];
      #1;
      check($sformatf("R%0d", VEC[i][28:25]), "warn_n", warn_n, VEC[i][2]);
      check($sformatf("R%0d", VEC[i][28:25]), "fault_n", fault_n, VEC[i][1]);
      check($sformatf("R%0d", VEC[i][28:25]), "out_off", out_off, VEC[i][0]);
    end
    @(negedge clk);
    temp_code = 8'd25; vsup_code = 8'd120; pwr_en = 1'b1; tri_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R9", "fault_n idle", fault_n, 1'b1);

    // R3: overcurrent trips in the same cycle
    ovc_flag = 4'b0100;
    #1;
    check("R3", "fault_n", fault_n, 1'b0);
    check("R3", "out_off", out_off, 1'b1);
    @(negedge clk) ovc_flag = 4'h0;
    repeat (3) @(negedge clk);
    check("R5", "fault_n held", fault_n, 1'b0);
    check("R5", "out_off held", out_off, 1'b1);

    // R6: release exactly on the third edge after tri_n returns high
    @(negedge clk) tri_n = 1'b0;
    repeat (4) @(negedge clk);
    tri_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R6", "fault_n after 2 edges", fault_n, 1'b0);
    @(posedge clk); #1;
    check("R6", "fault_n after 3 edges", fault_n, 1'b1);
    check("R6", "out_off after clear", out_off, 1'b0);

    // R8: clearing while overcurrent persists
    @(negedge clk) ovc_flag = 4'b0001;
    clear_seq();
    check("R8", "fault_n ovc present", fault_n, 1'b0);
    ovc_flag = 4'h0;
    repeat (2) @(negedge clk);
    check("R5", "fault_n after ovc gone", fault_n, 1'b0);
    clear_seq();
    check("R6", "fault_n cleared", fault_n, 1'b1);

    // R2: thermal trip and hysteresis
    temp_code = 8'd150;
    #1;
    check("R2", "fault_n at 150", fault_n, 1'b0);
    check("R2", "out_off at 150", out_off, 1'b1);
    check("R1", "warn_n at 150", warn_n, 1'b0);
    @(negedge clk) temp_code = 8'd140;
    clear_seq();
    check("R2", "fault_n at 140 after clear", fault_n, 1'b0);
    temp_code = 8'd126;
    clear_seq();
    check("R2", "fault_n at 126 after clear", fault_n, 1'b0);
    check("R1", "warn_n at 126", warn_n, 1'b1);
    temp_code = 8'd125;
    repeat (2) @(negedge clk);
    check("R5", "fault_n at 125 before clear", fault_n, 1'b0);
    clear_seq();
    check("R2", "fault_n at 125 after clear", fault_n, 1'b1);
    check("R2", "out_off at 125 after clear", out_off, 1'b0);

    // R4: undervoltage never latches, R7: power-down leaves fault_n alone
    vsup_code = 8'd10;
    @(negedge clk);
    check("R4", "fault_n under uv", fault_n, 1'b1);
    vsup_code = 8'd40;
    #1;
    check("R4", "out_off after uv", out_off, 1'b0);
    @(negedge clk) ovc_flag = 4'b1000; pwr_en = 1'b0;
    @(negedge clk) ovc_flag = 4'h0;
    @(negedge clk);
    check("R7", "fault_n during power-down", fault_n, 1'b0);
    check("R7", "out_off during power-down", out_off, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule